// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable, clock-sampled functional model of a 16-bit-wide static memory. It has a low-active and a high-active chip select, two byte-lane enables, a write strobe and an output enable. On every rising clock edge it samples these controls and picks one of four modes: idle (deselected), read, quiet (selected with outputs off) or write. It drives a per-lane read bus and updates only the byte lanes that are enabled. The usual bidirectional data pins are split into a data-in bus, a data-out bus and a two-bit per-lane drive enable. A standby flag shows when the part is deselected. The depth is a parameter, so the array stays small in simulation.

The mode sequencer is an enumerated state machine. Its four states are MODE_IDLE, MODE_READ, MODE_QUIET and MODE_WRITE. Every edge moves it to the mode decoded from the sampled controls. The transition that matters is the write-end transition, MODE_WRITE to any other state. On that transition the write is committed to the array, using the address, data and lanes sampled in the last write cycle. This models a write that is captured at the edge that terminates it. A reset sends the machine to MODE_IDLE at once and drops any write that is still open.

Top module: `byte_lane_sram_model`

## Requirements
- R1: The part counts as selected only when `cs1_n` is 0 and `cs2` is 1. Otherwise the mode is idle (`mode`=0), `standby` is 1, `drive_en` is 00, and a write strobe stores nothing.
- R2: If both `byte_n` bits are 1, the mode is idle, `standby` is 1 and `drive_en` is 00, whatever `we_n` and `oe_n` are. No lane is written.
- R3: `mode`, `standby`, `drive_en` and `dout` reflect the controls sampled at the previous rising clock edge. The mode encoding is 0 idle, 1 read, 2 quiet, 3 write.
- R4: When selected with `we_n`=0, the mode is write (3) and `drive_en` is 00, whatever `oe_n` is.
- R5: A write is committed on the edge where the write condition goes from true to false. It uses the address, data and lanes sampled in the last write cycle. Addresses presented earlier in the same write are left untouched.
- R6: In a write, `byte_n[0]`=0 stores `din[7:0]` and `byte_n[1]`=0 stores `din[15:8]`. A lane whose enable is 1 keeps its old contents.
- R7: When selected with `we_n`=1 and `oe_n`=0, the mode is read (1). `drive_en[0]` equals the inverse of `byte_n[0]` and `drive_en[1]` equals the inverse of `byte_n[1]`. A driven lane shows the stored byte, and an undriven lane of `dout` is zero.
- R8: When selected with `we_n`=1 and `oe_n`=1, the mode is quiet (2), `standby` is 0 and `drive_en` is 00.
- R9: While `rst_n` is 0, the mode is idle, `standby` is 1 and `drive_en` is 00. A write still open when reset is asserted is discarded.
- R10: A read that directly follows the end of a write to the same address returns the newly written data in its first read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_n | input | 2 | Lane enables, active low; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, zero on undriven lanes |
| drive_en | output | 2 | Per-lane drive enable (bit 0 low lane) |
| standby | output | 1 | High while deselected |
| mode | output | 2 | Current mode: 0 idle, 1 read, 2 quiet, 3 write |

## Verification
Each mode, standby and drive result is due one rising edge after the controls are applied. The bench drives on a falling edge and samples at the next falling edge, after exactly one rising edge. A write becomes visible only after the edge that ends it. Scenarios therefore follow a write cycle with either an idle cycle or a direct read. They read back one edge later, or in the same cycle as the read for the back-to-back case of R10. Ignored writes (deselected, no lanes, reset-aborted) are checked by reading the target address afterwards and comparing it with the data stored before.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_READ  = 2'd1,
        MODE_QUIET = 2'd2,
        MODE_WRITE = 2'd3
    } sram_mode_e;

    // Decode sampled controls into an access mode.
    function automatic sram_mode_e decode_mode(
        input logic       sel_lo_n,
        input logic       sel_hi,
        input logic [1:0] lanes_n,
        input logic       wr_n,
        input logic       rd_n
    );
        if (sel_lo_n || !sel_hi || (&lanes_n))
            return MODE_IDLE;
        else if (!wr_n)
            return MODE_WRITE;
        else if (!rd_n)
            return MODE_READ;
        else
            return MODE_QUIET;
    endfunction

endpackage

// File: rtl/sram_mode_fsm.sv
module sram_mode_fsm
    import sram_model_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs1_n,
    input  logic       cs2,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic [1:0] byte_n,
    output sram_mode_e state,
    output logic       commit
);

    sram_mode_e state_q;
    sram_mode_e next_state;
    sram_mode_e sampled;

    assign sampled = decode_mode(cs1_n, cs2, byte_n, we_n, oe_n);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= MODE_IDLE;
        else
            state_q <= next_state;
    end

    // Next state and write-end transition
    always_comb begin
        next_state = sampled;
        commit     = 1'b0;
        unique case (state_q)
            MODE_IDLE:  next_state = sampled;
            MODE_READ:  next_state = sampled;
            MODE_QUIET: next_state = sampled;
            MODE_WRITE: begin
                next_state = sampled;
                commit     = (sampled != MODE_WRITE);
            end
            default:    next_state = MODE_IDLE;
        endcase
    end

    assign state = state_q;

    // R5: a commit only ever leaves the write state
    p_commit_leaves_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q != MODE_WRITE));

    // R1: a deselecting cs1_n always lands in idle
    p_cs1_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs1_n |=> (state_q == MODE_IDLE));

endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    wr_commit,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_commit && wr_lanes[g])
                bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/byte_lane_sram_model.sv
module byte_lane_sram_model
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                cs1_n,
    input  logic                cs2,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [1:0]          byte_n,
    input  logic [2*LANE_W-1:0] din,
    output logic [2*LANE_W-1:0] dout,
    output logic [1:0]          drive_en,
    output logic                standby,
    output logic [1:0]          mode
);

    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;

    sram_mode_e          state;
    logic                commit;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   din_q;
    logic [LANES-1:0]    lanes_q;
    logic [DATA_W-1:0]   rd_word;

    sram_mode_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs1_n  (cs1_n),
        .cs2    (cs2),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .byte_n (byte_n),
        .state  (state),
        .commit (commit)
    );

    // Capture address, data and lanes alongside the mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            din_q   <= '0;
            lanes_q <= '0;
        end else begin
            addr_q  <= addr;
            din_q   <= din;
            lanes_q <= ~byte_n;
        end
    end

    sram_lane_store #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_store (
        .clk       (clk),
        .wr_commit (commit && rst_n),
        .wr_addr   (addr_q),
        .wr_lanes  (lanes_q),
        .wr_data   (din_q),
        .rd_addr   (addr_q),
        .rd_data   (rd_word)
    );

    // Output process
    always_comb begin
        drive_en = '0;
        standby  = 1'b0;
        unique case (state)
            MODE_IDLE:  standby  = 1'b1;
            MODE_READ:  drive_en = lanes_q;
            MODE_QUIET: drive_en = '0;
            MODE_WRITE: drive_en = '0;
            default:    standby  = 1'b1;
        endcase
        for (int i = 0; i < LANES; i++)
            dout[i*LANE_W +: LANE_W] = drive_en[i] ? rd_word[i*LANE_W +: LANE_W] : '0;
    end

    assign mode = state;

    // R4: no lane is driven while writing
    p_write_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (drive_en == 2'b00));

    // R2: both lane enables off gives standby on the next cycle
    p_lanes_off_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&byte_n) |=> standby);

    // R7: in read, driven lanes follow the sampled lane enables
    p_read_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (drive_en == ~$past(byte_n)));

    // R8: quiet mode is active but drives nothing
    p_quiet_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (!standby && drive_en == 2'b00));

endmodule

// File: tb/byte_lane_sram_model_bench.sv
module byte_lane_sram_model_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr = '0;
    logic        cs1_n = 1'b1, cs2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic [1:0]  byte_n = 2'b11;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic [1:0]  drive_en;
    logic        standby;
    logic [1:0]  mode;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    byte_lane_sram_model u_byte_lane_sram_model (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2),
        .we_n(we_n), .oe_n(oe_n), .byte_n(byte_n), .din(din),
        .dout(dout), .drive_en(drive_en), .standby(standby), .mode(mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive inputs at a falling edge, then wait one full cycle.
    task automatic apply(input logic c1n, input logic c2, input logic wn, input logic on,
                         input logic [1:0] bn, input logic [9:0] a, input logic [15:0] d);
        cs1_n = c1n; cs2 = c2; we_n = wn; oe_n = on; byte_n = bn; addr = a; din = d;
        @(negedge clk);
    endtask

    task automatic idle();
        apply(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, '0, '0);
    endtask

    task automatic write_word(input logic [9:0] a, input logic [15:0] d, input logic [1:0] bn);
        apply(1'b0, 1'b1, 1'b0, 1'b1, bn, a, d);
        idle();
    endtask

    task automatic read_chk(input string req, input logic [9:0] a, input logic [1:0] bn,
                            input logic [15:0] exp);
        apply(1'b0, 1'b1, 1'b1, 1'b0, bn, a, '0);
        chk(req, {30'd0, mode}, 32'd1);
        chk(req, {30'd0, drive_en}, {30'd0, ~bn});
        chk(req, {16'd0, dout}, {16'd0, exp});
    endtask

    task automatic t_reset();
        chk("R9 reset mode", {30'd0, mode}, 32'd0);
        chk("R9 reset standby", {31'd0, standby}, 32'd1);
        chk("R9 reset drive", {30'd0, drive_en}, 32'd0);
    endtask

    task automatic t_write_read();
        apply(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 10'd5, 16'h1234);
        chk("R4 write mode with oe low", {30'd0, mode}, 32'd3);
        chk("R4 no drive in write", {30'd0, drive_en}, 32'd0);
        chk("R3 write not standby", {31'd0, standby}, 32'd0);
        idle();
        chk("R3 idle after write", {30'd0, mode}, 32'd0);
        read_chk("R7 full read", 10'd5, 2'b00, 16'h1234);
        chk("R3 read not standby", {31'd0, standby}, 32'd0);
    endtask

    task automatic t_back_to_back();
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 10'd6, 16'hBEEF);
        read_chk("R10 read right after write", 10'd6, 2'b00, 16'hBEEF);
        idle();
    endtask

    task automatic t_lanes();
        write_word(10'd7, 16'hAAAA, 2'b00);
        write_word(10'd7, 16'h1155, 2'b10);
        read_chk("R6 low lane only", 10'd7, 2'b00, 16'hAA55);
        write_word(10'd7, 16'h77CC, 2'b01);
        read_chk("R6 high lane only", 10'd7, 2'b00, 16'h7755);
        read_chk("R7 low lane read", 10'd7, 2'b10, 16'h0055);
        read_chk("R7 high lane read", 10'd7, 2'b01, 16'h7700);
        idle();
    endtask

    task automatic t_quiet();
        apply(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 10'd7, '0);
        chk("R8 quiet mode", {30'd0, mode}, 32'd2);
        chk("R8 quiet not standby", {31'd0, standby}, 32'd0);
        chk("R8 quiet no drive", {30'd0, drive_en}, 32'd0);
        idle();
    endtask

    task automatic t_deselect();
        apply(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 10'd7, '0);
        chk("R1 cs1_n high mode", {30'd0, mode}, 32'd0);
        chk("R1 cs1_n high standby", {31'd0, standby}, 32'd1);
        chk("R1 cs1_n high drive", {30'd0, drive_en}, 32'd0);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd7, '0);
        chk("R1 cs2 low mode", {30'd0, mode}, 32'd0);
        chk("R1 cs2 low drive", {30'd0, drive_en}, 32'd0);
        apply(1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 10'd7, 16'h0000);
        apply(1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 10'd7, 16'h0000);
        idle();
        read_chk("R1 deselected write ignored", 10'd7, 2'b00, 16'h7755);
        idle();
    endtask

    task automatic t_lanes_off();
        apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 10'd7, '0);
        chk("R2 lanes off read mode", {30'd0, mode}, 32'd0);
        chk("R2 lanes off standby", {31'd0, standby}, 32'd1);
        chk("R2 lanes off drive", {30'd0, drive_en}, 32'd0);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 10'd7, 16'h0000);
        chk("R2 lanes off write mode", {30'd0, mode}, 32'd0);
        idle();
        read_chk("R2 lanes off write ignored", 10'd7, 2'b00, 16'h7755);
        idle();
    endtask

    task automatic t_commit_last();
        write_word(10'd10, 16'h0A0A, 2'b00);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 10'd10, 16'h1111);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 10'd11, 16'h2222);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 10'd11, 16'h3333);
        idle();
        read_chk("R5 last sampled data stored", 10'd11, 2'b00, 16'h3333);
        read_chk("R5 earlier address untouched", 10'd10, 2'b00, 16'h0A0A);
        idle();
    endtask

    task automatic t_reset_abort();
        write_word(10'd12, 16'h5A5A, 2'b00);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 10'd12, 16'hFFFF);
        rst_n = 1'b0;
        cs1_n = 1'b1; cs2 = 1'b0; we_n = 1'b1; byte_n = 2'b11;
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        read_chk("R9 aborted write discarded", 10'd12, 2'b00, 16'h5A5A);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write_read();
        t_back_to_back();
        t_lanes();
        t_quiet();
        t_deselect();
        t_lanes_off();
        t_commit_last();
        t_reset_abort();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule